// File: doc/BRIEF.md
# CCD sampling clock generator

This block produces the per-pixel timing for a correlated double sampling front end. It runs from a single master clock at sixteen times the pixel rate. A 4-bit phase counter steps through the sixteen master cycles of each pixel, and the counter uses rising edges only, so the master-clock duty cycle does not affect the timing. Three outputs come from this counter: a clamp/reset-level sample pulse, a video-level sample pulse and a converter clock. Each output has a programmable start phase and stop phase, and each is driven straight from a flip-flop.

A line-start pulse begins a line. A pixel counter then runs for a programmable number of pixels. In windowed operation, the clamp pulse appears only on a programmable number of optical black pixels at the head of the line. In continuous operation, the clamp pulse appears on every pixel, and all three outputs keep running after the line ends, which gives the input coupling capacitor more charging time between lines, for example while the carriage moves. Configuration is captured only on line start, so a line never mixes two timing setups.

Top module: `ccd_sample_timing`

## Requirements
- R1: Synchronous reset drives all three outputs low. After reset, the outputs stay low until a line-start pulse arrives.
- R2: One pixel lasts exactly 16 master cycles. Outputs change only on rising master-clock edges.
- R3: Let line start be sampled at edge E0. After edge Ek (k ≥ 1), each output is high exactly when its window contains phase p = (k-1) mod 16. When start < stop, the window is start ≤ p < stop.
- R4: When start > stop, the window wraps and covers p ≥ start or p < stop. When start equals stop, the output never asserts.
- R5: In windowed operation, the clamp pulse is allowed only in pixels whose index (counted from 0) is below the optical-black count. A count of 0 gives no clamp pulse. A count at or above the line length gives a clamp pulse on every pixel.
- R6: The video sample pulse and the converter clock appear on every pixel of a line.
- R7: In windowed operation, all outputs are low from the first pixel slot after the last pixel until the next line start.
- R8: In continuous operation, the clamp pulse appears on every pixel. All three outputs keep their 16-cycle pattern after the line ends, with no phase break.
- R9: Configuration inputs are captured only on line start. Changes made during a line take effect on the next line.
- R10: A line-start pulse in the middle of a line restarts the line at pixel 0, phase 0, with the newly captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 16x pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | Begins a line and captures configuration |
| cfg_clamp_on | input | 4 | Clamp pulse start phase |
| cfg_clamp_off | input | 4 | Clamp pulse stop phase |
| cfg_video_on | input | 4 | Video sample start phase |
| cfg_video_off | input | 4 | Video sample stop phase |
| cfg_conv_on | input | 4 | Converter clock start phase |
| cfg_conv_off | input | 4 | Converter clock stop phase |
| cfg_line_len | input | PIX_W | Pixels per line (1 or more) |
| cfg_black_cnt | input | PIX_W | Optical black pixels with clamp |
| cfg_continuous | input | 1 | Clamp every pixel and keep running between lines |
| clamp_smp | output | 1 | Reset-level sample / clamp pulse |
| video_smp | output | 1 | Video-level sample pulse |
| conv_clk | output | 1 | Converter clock |

## Verification
The assertions are checked on every cycle. They cover the following:
- The phase counter steps by one while running.
- The outputs are quiet whenever the sequencer is neither inside a line nor in continuous operation.
- A clamp pulse is never issued outside the optical-black allowance.
- The captured configuration holds steady between line starts.

The exact position of each pulse inside a pixel, wrapping and empty windows, the end of line, the capture of settings made in mid-line, and a restart in the middle of a line can only be shown by the bench scenarios. The bench compares every output on every cycle against a model of the expected pulses.

// File: rtl/ccd_sample_timing.sv
module ccd_sample_timing #(
  parameter int PIX_W = 13,
  parameter logic [3:0] DEF_CLAMP_ON  = 4'd1,
  parameter logic [3:0] DEF_CLAMP_OFF = 4'd4,
  parameter logic [3:0] DEF_VIDEO_ON  = 4'd8,
  parameter logic [3:0] DEF_VIDEO_OFF = 4'd11,
  parameter logic [3:0] DEF_CONV_ON   = 4'd12,
  parameter logic [3:0] DEF_CONV_OFF  = 4'd15,
  parameter int DEF_LINE_LEN  = 5000,
  parameter int DEF_BLACK_CNT = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [3:0]       cfg_clamp_on,
  input  logic [3:0]       cfg_clamp_off,
  input  logic [3:0]       cfg_video_on,
  input  logic [3:0]       cfg_video_off,
  input  logic [3:0]       cfg_conv_on,
  input  logic [3:0]       cfg_conv_off,
  input  logic [PIX_W-1:0] cfg_line_len,
  input  logic [PIX_W-1:0] cfg_black_cnt,
  input  logic             cfg_continuous,
  output logic             clamp_smp,
  output logic             video_smp,
  output logic             conv_clk
);
  localparam int PH_W = 4;
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0]  phase, ph_inc;
  logic [PIX_W-1:0] pix;
  logic             active;

  logic [PH_W-1:0]  s_clamp_on, s_clamp_off, s_video_on, s_video_off, s_conv_on, s_conv_off;
  logic [PIX_W-1:0] s_line_len, s_black_cnt;
  logic             s_cont;

  function automatic logic in_win(input logic [PH_W-1:0] p, on, off);
    return (on <= off) ? (p >= on && p < off) : (p >= on || p < off);
  endfunction

  logic running, clamp_ok, last_pix;
  assign running  = active | s_cont;
  assign clamp_ok = s_cont | (pix < s_black_cnt);
  assign last_pix = (pix + 1'b1) == s_line_len;
  assign ph_inc   = phase + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= '0;
      pix         <= '0;
      active      <= 1'b0;
      clamp_smp   <= 1'b0;
      video_smp   <= 1'b0;
      conv_clk    <= 1'b0;
      s_clamp_on  <= DEF_CLAMP_ON;
      s_clamp_off <= DEF_CLAMP_OFF;
      s_video_on  <= DEF_VIDEO_ON;
      s_video_off <= DEF_VIDEO_OFF;
      s_conv_on   <= DEF_CONV_ON;
      s_conv_off  <= DEF_CONV_OFF;
      s_line_len  <= PIX_W'(DEF_LINE_LEN);
      s_black_cnt <= PIX_W'(DEF_BLACK_CNT);
      s_cont      <= 1'b0;
    end else begin
      clamp_smp <= running & clamp_ok & in_win(phase, s_clamp_on, s_clamp_off);
      video_smp <= running & in_win(phase, s_video_on, s_video_off);
      conv_clk  <= running & in_win(phase, s_conv_on, s_conv_off);
      if (line_start) begin
        phase       <= '0;
        pix         <= '0;
        active      <= 1'b1;
        s_clamp_on  <= cfg_clamp_on;
        s_clamp_off <= cfg_clamp_off;
        s_video_on  <= cfg_video_on;
        s_video_off <= cfg_video_off;
        s_conv_on   <= cfg_conv_on;
        s_conv_off  <= cfg_conv_off;
        s_line_len  <= cfg_line_len;
        s_black_cnt <= cfg_black_cnt;
        s_cont      <= cfg_continuous;
      end else begin
        phase <= running ? ph_inc : '0;
        if (active && phase == PH_LAST) begin
          if (last_pix) begin
            active <= 1'b0;
            pix    <= '0;
          end else begin
            pix <= pix + 1'b1;
          end
        end
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!clamp_smp && !video_smp && !conv_clk));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (running && !line_start) |=> phase == $past(ph_inc));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!running && !line_start) |=> (!clamp_smp && !video_smp && !conv_clk));

  assert_clamp_allowed_R5: assert property (@(posedge clk) disable iff (rst)
    clamp_smp |-> $past(clamp_ok && running));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> ($stable(s_line_len) && $stable(s_black_cnt) && $stable(s_cont)
                     && $stable(s_clamp_on) && $stable(s_video_off)));
endmodule

// File: tb/ccd_sample_timing_tb.sv
module ccd_sample_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 13;

  logic clk = 1'b0, rst = 1'b1, line_start = 1'b0;
  logic [3:0] c_on, c_off, v_on, v_off, a_on, a_off;
  logic [PIX_W-1:0] len, blk;
  logic cont;
  logic clamp_smp, video_smp, conv_clk;

  logic [3:0] l_c_on, l_c_off, l_v_on, l_v_off, l_a_on, l_a_off;
  int l_len, l_blk;
  logic l_cont;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_sample_timing #(.PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst(rst), .line_start(line_start),
    .cfg_clamp_on(c_on), .cfg_clamp_off(c_off),
    .cfg_video_on(v_on), .cfg_video_off(v_off),
    .cfg_conv_on(a_on), .cfg_conv_off(a_off),
    .cfg_line_len(len), .cfg_black_cnt(blk), .cfg_continuous(cont),
    .clamp_smp(clamp_smp), .video_smp(video_smp), .conv_clk(conv_clk));

  function automatic logic win(int p, logic [3:0] on, logic [3:0] off);
    if (on <= off) return (p >= on && p < off);
    return (p >= on || p < off);
  endfunction

  function automatic logic [2:0] expect_at(int k);
    int m = k - 1;
    int px = m / 16;
    int ph = m % 16;
    logic run = (px < l_len) || l_cont;
    logic ok  = l_cont || (px < l_blk);
    if (!run) return 3'b000;
    return {ok && win(ph, l_c_on, l_c_off), win(ph, l_v_on, l_v_off), win(ph, l_a_on, l_a_off)};
  endfunction

  task automatic set_cfg(int co, int cf, int vo, int vf, int ao, int af, int ln, int bk, bit ct);
    c_on = 4'(co); c_off = 4'(cf); v_on = 4'(vo); v_off = 4'(vf);
    a_on = 4'(ao); a_off = 4'(af); len = PIX_W'(ln); blk = PIX_W'(bk); cont = ct;
  endtask

  task automatic rand_cfg();
    set_cfg($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16,
            $urandom % 16, $urandom % 16, 1 + $urandom % 6, $urandom % 8, ($urandom % 4) == 0);
  endtask

  task automatic start_line();
    @(negedge clk);
    line_start = 1'b1;
    l_c_on = c_on; l_c_off = c_off; l_v_on = v_on; l_v_off = v_off;
    l_a_on = a_on; l_a_off = a_off; l_len = int'(len); l_blk = int'(blk); l_cont = cont;
    @(negedge clk);
    line_start = 1'b0;
    rand_cfg();
  endtask

  task automatic check_run(int n, string tag);
    for (int k = 1; k <= n; k++) begin
      logic [2:0] e;
      @(negedge clk);
      e = expect_at(k);
      total++;
      if ({clamp_smp, video_smp, conv_clk} !== e) begin
        bad++;
        $display("FAIL %s k=%0d got=%b exp=%b", tag, k, {clamp_smp, video_smp, conv_clk}, e);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R2 got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    set_cfg(1, 4, 8, 11, 12, 15, 4, 2, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      total++;
      if ({clamp_smp, video_smp, conv_clk} !== 3'b000) begin
        bad++;
        $display("FAIL R1 cycle=%0d got=%b exp=000", i, {clamp_smp, video_smp, conv_clk});
      end
    end
    set_cfg(1, 4, 8, 11, 12, 15, 4, 2, 1'b0);
    start_line(); check_run(4*16 + 24, "R3 R5 R6 R7 typical");
    set_cfg(14, 2, 5, 5, 13, 3, 3, 9, 1'b0);
    start_line(); check_run(3*16 + 20, "R4 wrap/empty, R5 full black");
    set_cfg(0, 3, 6, 9, 10, 12, 3, 0, 1'b0);
    start_line(); check_run(3*16 + 20, "R5 zero black");
    set_cfg(2, 5, 7, 10, 11, 14, 2, 0, 1'b1);
    start_line(); check_run(2*16 + 48, "R8 continuous");
    set_cfg(1, 4, 8, 11, 12, 15, 5, 3, 1'b0);
    start_line(); check_run(37, "R10 before restart");
    set_cfg(3, 6, 9, 12, 13, 1, 2, 1, 1'b0);
    start_line(); check_run(2*16 + 20, "R10 after restart");
    for (int n = 0; n < 30; n++) begin
      start_line();
      check_run(l_len * 16 + 20, "R9 R2 R3 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule